// File: doc/BRIEF.md
# Window Watchdog with Hysteresis

This block supervises a periodic trigger produced by a processor. It measures the spacing between rising trigger edges in ticks of a separate time-base enable. Each spacing is judged good when it falls inside a window, and bad when it is too short or too long. The verdict moves a credit counter that saturates at both ends of the range 0 to 3. A watchdog-OK flag turns on when three credits are reached. It stays on while the credit falls through 2 and 1, and drops only when the credit returns to 0.

The window widens by one tick at each end while OK is set. This hysteresis keeps a trigger running near a window edge from toggling the OK flag. If no trigger edge arrives for a full dropout span of ticks, the credit is cleared at once, without waiting for an edge. An oscillator-error flag and a synchronous reset also force the credit and the OK flag low. With the default settings, ticks run at about 100 times the trigger rate, so a nominal interval is about 100 ticks.

Top module: `win_wdog`

## Requirements
- R1: While `rst` is high, `credit_o` becomes 0, `wd_ok_o` becomes 0, both strobes become 0 and the interval count is cleared. The count restarts from 0 after `rst` falls.
- R2: A good interval adds one credit. At 3 the credit stays at 3.
- R3: A bad interval removes one credit. At 0 the credit stays at 0.
- R4: `wd_ok_o` goes high in the update that brings the credit to 3. It stays high at credits 2 and 1 and goes low in the update that brings the credit to 0.
- R5: While `wd_ok_o` is low, an interval is good only when it lies in LO_EDGE to HI_EDGE ticks, both ends included.
- R6: While `wd_ok_o` is high, an interval is good when it lies in LO_EDGE-1 to HI_EDGE+1 ticks, both ends included.
- R7: When DROP_TICKS ticks have been counted since the last edge, the credit and `wd_ok_o` go to 0 on that tick. The count then saturates, and the next edge is judged bad.
- R8: While `osc_err_i` is high, the credit and `wd_ok_o` are 0 from the next clock edge on. Intervals judged meanwhile are lost.
- R9: The interval value is the number of clock cycles with `tick_i` high strictly between two detected edges. A tick in the cycle of an edge is not counted. `trig_i` passes through SYNC_STAGES flops. The credit and the strobes update on the (SYNC_STAGES+1)-th rising clock edge after `trig_i` rises.
- R10: Each detected edge gives a single one-cycle pulse, on `good_o` or on `bad_o` (never both), in the same cycle as the credit update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Time-base tick enable, one clock wide |
| trig_i | input | 1 | Asynchronous trigger from the supervised processor |
| osc_err_i | input | 1 | Time-base failure flag, active high |
| wd_ok_o | output | 1 | Watchdog-OK flag |
| credit_o | output | 2 | Current credit count, 0 to 3 |
| good_o | output | 1 | One-cycle pulse: last interval inside the window |
| bad_o | output | 1 | One-cycle pulse: last interval outside the window |

## Verification
The bench builds the block with LO_EDGE=8, HI_EDGE=16 and DROP_TICKS=24. It keeps the default two synchronizer stages and hysteresis enabled. These short values put both window boundaries, in both OK states, the one-tick hysteresis shift, and the dropout within a few dozen cycles. The credit walk up to 3 and back down to 0 can then be tested repeatedly. Holding the tick low for part of an interval shows that only ticks are measured and not clock cycles.

// File: rtl/win_wdog_pkg.sv
package win_wdog_pkg;
   typedef logic [1:0] credit_t;
   localparam credit_t CREDIT_MAX  = 2'd3;
   localparam credit_t CREDIT_ZERO = 2'd0;
endpackage

// File: rtl/wdog_trig_edge.sv
module wdog_trig_edge #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst,
   input  logic trig_i,
   output logic rise_o
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   last_q;

   for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) sync_q[0] <= 1'b0;
            else     sync_q[0] <= trig_i;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) sync_q[g] <= 1'b0;
            else     sync_q[g] <= sync_q[g-1];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (rst) last_q <= 1'b0;
      else     last_q <= sync_q[SYNC_STAGES-1];
   end

   assign rise_o = sync_q[SYNC_STAGES-1] & ~last_q;
endmodule

// File: rtl/wdog_interval.sv
module wdog_interval #(
   parameter int DROP_TICKS = 250,
   parameter int CNT_W      = $clog2(DROP_TICKS + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick_i,
   input  logic             rise_i,
   output logic [CNT_W-1:0] count_o,
   output logic             drop_o
);
   localparam logic [CNT_W-1:0] SAT_VAL  = CNT_W'(DROP_TICKS);
   localparam logic [CNT_W-1:0] LAST_VAL = CNT_W'(DROP_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst)                           cnt_q <= '0;
      else if (rise_i)                   cnt_q <= '0;
      else if (tick_i && cnt_q != SAT_VAL) cnt_q <= cnt_q + 1'b1;
   end

   assign count_o = cnt_q;
   assign drop_o  = tick_i & ~rise_i & (cnt_q == LAST_VAL);
endmodule

// File: rtl/wdog_window.sv
module wdog_window #(
   parameter int LO_EDGE = 80,
   parameter int HI_EDGE = 169,
   parameter int CNT_W   = 8,
   parameter bit HYST_EN = 1'b1
) (
   input  logic [CNT_W-1:0] count_i,
   input  logic             ok_i,
   output logic             in_win_o
);
   localparam logic [CNT_W-1:0] LO_TIGHT = CNT_W'(LO_EDGE);
   localparam logic [CNT_W-1:0] HI_TIGHT = CNT_W'(HI_EDGE);
   localparam logic [CNT_W-1:0] LO_WIDE  = CNT_W'(LO_EDGE - 1);
   localparam logic [CNT_W-1:0] HI_WIDE  = CNT_W'(HI_EDGE + 1);

   logic [CNT_W-1:0] lo_eff, hi_eff;

   if (HYST_EN) begin : g_hyst
      assign lo_eff = ok_i ? LO_WIDE : LO_TIGHT;
      assign hi_eff = ok_i ? HI_WIDE : HI_TIGHT;
   end else begin : g_fixed
      logic unused_ok;
      assign unused_ok = ok_i;
      assign lo_eff = LO_TIGHT;
      assign hi_eff = HI_TIGHT;
   end

   assign in_win_o = (count_i >= lo_eff) && (count_i <= hi_eff);
endmodule

// File: rtl/wdog_credit.sv
module wdog_credit
   import win_wdog_pkg::*;
(
   input  logic    clk,
   input  logic    rst,
   input  logic    osc_err_i,
   input  logic    drop_i,
   input  logic    rise_i,
   input  logic    in_win_i,
   output credit_t credit_o,
   output logic    ok_o,
   output logic    good_o,
   output logic    bad_o
);
   credit_t credit_q, credit_nxt;
   logic    ok_q, good_q, bad_q;

   always_comb begin
      if (in_win_i) credit_nxt = (credit_q == CREDIT_MAX)  ? CREDIT_MAX  : credit_q + 2'd1;
      else          credit_nxt = (credit_q == CREDIT_ZERO) ? CREDIT_ZERO : credit_q - 2'd1;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         credit_q <= CREDIT_ZERO;
         ok_q     <= 1'b0;
         good_q   <= 1'b0;
         bad_q    <= 1'b0;
      end else begin
         good_q <= rise_i &  in_win_i;
         bad_q  <= rise_i & ~in_win_i;
         if (osc_err_i || drop_i) begin
            credit_q <= CREDIT_ZERO;
            ok_q     <= 1'b0;
         end else if (rise_i) begin
            credit_q <= credit_nxt;
            if (credit_nxt == CREDIT_MAX)       ok_q <= 1'b1;
            else if (credit_nxt == CREDIT_ZERO) ok_q <= 1'b0;
         end
      end
   end

   assign credit_o = credit_q;
   assign ok_o     = ok_q;
   assign good_o   = good_q;
   assign bad_o    = bad_q;
endmodule

// File: rtl/win_wdog.sv
module win_wdog #(
   parameter int LO_EDGE     = 80,
   parameter int HI_EDGE     = 169,
   parameter int DROP_TICKS  = 250,
   parameter int SYNC_STAGES = 2,
   parameter bit HYST_EN     = 1'b1
) (
   input  logic       clk,
   input  logic       rst,
   input  logic       tick_i,
   input  logic       trig_i,
   input  logic       osc_err_i,
   output logic       wd_ok_o,
   output logic [1:0] credit_o,
   output logic       good_o,
   output logic       bad_o
);
   localparam int CNT_W = $clog2(DROP_TICKS + 1);

   initial begin
      assert (LO_EDGE >= 2) else $error("win_wdog: LO_EDGE must be at least 2");
      assert (HI_EDGE >= LO_EDGE) else $error("win_wdog: HI_EDGE below LO_EDGE");
      assert (DROP_TICKS > HI_EDGE + 1) else $error("win_wdog: DROP_TICKS inside window");
      assert (SYNC_STAGES >= 2) else $error("win_wdog: need two synchronizer stages");
   end

   logic             rise;
   logic             drop;
   logic             in_win;
   logic [CNT_W-1:0] count;

   wdog_trig_edge #(.SYNC_STAGES(SYNC_STAGES)) u_edge (
      .clk(clk), .rst(rst), .trig_i(trig_i), .rise_o(rise)
   );

   wdog_interval #(.DROP_TICKS(DROP_TICKS), .CNT_W(CNT_W)) u_intv (
      .clk(clk), .rst(rst), .tick_i(tick_i), .rise_i(rise),
      .count_o(count), .drop_o(drop)
   );

   wdog_window #(.LO_EDGE(LO_EDGE), .HI_EDGE(HI_EDGE), .CNT_W(CNT_W), .HYST_EN(HYST_EN)) u_win (
      .count_i(count), .ok_i(wd_ok_o), .in_win_o(in_win)
   );

   wdog_credit u_credit (
      .clk(clk), .rst(rst), .osc_err_i(osc_err_i), .drop_i(drop),
      .rise_i(rise), .in_win_i(in_win), .credit_o(credit_o),
      .ok_o(wd_ok_o), .good_o(good_o), .bad_o(bad_o)
   );
endmodule

// File: rtl/win_wdog_chk.sv
module win_wdog_chk (
   input logic       clk,
   input logic       rst,
   input logic       osc_err_i,
   input logic [1:0] credit_o,
   input logic       wd_ok_o,
   input logic       good_o,
   input logic       bad_o
);
   // R1
   reset_clear_chk: assert property (@(posedge clk) rst |=> (credit_o == 2'd0 && !wd_ok_o && !good_o && !bad_o));

   // R4
   ok_at_full_chk: assert property (@(posedge clk) disable iff (rst) (credit_o == 2'd3) |-> wd_ok_o);

   // R4
   ok_off_at_zero_chk: assert property (@(posedge clk) disable iff (rst) (credit_o == 2'd0) |-> !wd_ok_o);

   // R8
   osc_hold_chk: assert property (@(posedge clk) disable iff (rst) osc_err_i |=> (credit_o == 2'd0 && !wd_ok_o));

   // R10
   one_verdict_chk: assert property (@(posedge clk) disable iff (rst) $onehot0({good_o, bad_o}));

   // R2
   good_step_chk: assert property (@(posedge clk) disable iff (rst)
      (good_o && !$past(osc_err_i) && !$past(rst)) |->
      credit_o == (($past(credit_o) == 2'd3) ? 2'd3 : $past(credit_o) + 2'd1));

   // R3
   bad_step_chk: assert property (@(posedge clk) disable iff (rst)
      (bad_o && !$past(osc_err_i) && !$past(rst)) |->
      credit_o == (($past(credit_o) == 2'd0) ? 2'd0 : $past(credit_o) - 2'd1));
endmodule

bind win_wdog win_wdog_chk chk_i (
   .clk(clk), .rst(rst), .osc_err_i(osc_err_i), .credit_o(credit_o),
   .wd_ok_o(wd_ok_o), .good_o(good_o), .bad_o(bad_o)
);

// File: tb/win_wdog_test.sv
module win_wdog_test;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       tick = 1'b1;
   logic       trig = 1'b0;
   logic       osc_err = 1'b0;
   logic       wd_ok;
   logic [1:0] credit;
   logic       good, bad;
   int         checks = 0;
   int         failures = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   win_wdog #(.LO_EDGE(8), .HI_EDGE(16), .DROP_TICKS(24)) uut (
      .clk(clk), .rst(rst), .tick_i(tick), .trig_i(trig), .osc_err_i(osc_err),
      .wd_ok_o(wd_ok), .credit_o(credit), .good_o(good), .bad_o(bad)
   );

   task automatic check(input string req, input int act_c, input int exp_c,
                        input int act_ok, input int exp_ok);
      checks++;
      if (act_c != exp_c || act_ok != exp_ok) begin
         failures++;
         $display("FAIL %s: credit=%0d ok=%0d expected credit=%0d ok=%0d",
                  req, act_c, act_ok, exp_c, exp_ok);
      end
   endtask

   task automatic check_strobe(input string req, input bit exp_good);
      checks++;
      if (good !== exp_good || bad !== !exp_good) begin
         failures++;
         $display("FAIL %s: good=%0b bad=%0b expected good=%0b bad=%0b",
                  req, good, bad, exp_good, !exp_good);
      end
   endtask

   // one-cycle trigger pulse, then wait until the update is visible (R9)
   task automatic edge_and_settle();
      trig = 1'b1;
      @(negedge clk);
      trig = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   // interval of v ticks after the previous edge; off cycles have no tick
   task automatic interval(input int v, input int off, input string req,
                           input int exp_c, input int exp_ok, input bit exp_good);
      for (int i = 0; i < v - 2; i++) begin
         tick = (i >= off);
         @(negedge clk);
      end
      tick = 1'b1;
      edge_and_settle();
      check(req, credit, exp_c, wd_ok, exp_ok);
      check_strobe(req, exp_good);
   endtask

   task automatic do_reset();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      check("R1 reset state", credit, 0, wd_ok, 0);
      rst = 1'b0;
      edge_and_settle();
      check("R3 saturate at zero", credit, 0, wd_ok, 0);
   endtask

   task automatic t_climb_and_fall();
      interval(12, 0, "R2 first good", 1, 0, 1'b1);
      interval(12, 0, "R4 no ok at two", 2, 0, 1'b1);
      interval(12, 0, "R4 ok at three", 3, 1, 1'b1);
      interval(12, 0, "R2 saturate at three", 3, 1, 1'b1);
      interval(7, 0, "R6 wide low edge", 3, 1, 1'b1);
      interval(17, 0, "R6 wide high edge", 3, 1, 1'b1);
      interval(6, 0, "R6 below wide window", 2, 1, 1'b0);
      interval(18, 0, "R4 ok held at one", 1, 1, 1'b0);
      interval(4, 0, "R4 ok off at zero", 0, 0, 1'b0);
   endtask

   task automatic t_tight_window();
      interval(7, 0, "R5 below tight low edge", 0, 0, 1'b0);
      interval(17, 0, "R5 above tight high edge", 0, 0, 1'b0);
      interval(8, 0, "R5 tight low edge", 1, 0, 1'b1);
      interval(16, 0, "R5 tight high edge", 2, 0, 1'b1);
      interval(9, 0, "R2 back to three", 3, 1, 1'b1);
   endtask

   task automatic t_tick_gating();
      interval(20, 10, "R9 only ticks counted", 3, 1, 1'b1);
      interval(20, 0, "R9 full ticks too slow", 2, 1, 1'b0);
      interval(12, 0, "R9 recover", 3, 1, 1'b1);
   endtask

   task automatic t_dropout();
      repeat (23) @(negedge clk);
      check("R7 before dropout", credit, 3, wd_ok, 1);
      @(negedge clk);
      check("R7 dropout clears", credit, 0, wd_ok, 0);
      repeat (10) @(negedge clk);
      edge_and_settle();
      check("R7 saturated count bad", credit, 0, wd_ok, 0);
      check_strobe("R7 saturated count bad", 1'b0);
   endtask

   task automatic t_osc_err();
      interval(12, 0, "R8 prep", 1, 0, 1'b1);
      interval(12, 0, "R8 prep", 2, 0, 1'b1);
      interval(12, 0, "R8 prep", 3, 1, 1'b1);
      osc_err = 1'b1;
      repeat (2) @(negedge clk);
      check("R8 forced low", credit, 0, wd_ok, 0);
      interval(10, 0, "R8 held during error", 0, 0, 1'b1);
      osc_err = 1'b0;
      interval(12, 0, "R8 resumes", 1, 0, 1'b1);
   endtask

   task automatic t_mid_reset();
      interval(12, 0, "R1 prep", 2, 0, 1'b1);
      rst = 1'b1;
      @(negedge clk);
      check("R1 reset mid run", credit, 0, wd_ok, 0);
      rst = 1'b0;
      @(negedge clk);
   endtask

   initial begin
      repeat (2) @(negedge clk);
      do_reset();
      t_climb_and_fall();
      t_tight_window();
      t_tick_gating();
      t_dropout();
      t_osc_err();
      t_mid_reset();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule